// File: doc/BRIEF.md
# Half-Duplex Collision Retry Controller

This block is the collision-handling core of a half-duplex Ethernet transmitter. The serialiser sends the frame. Alongside it, this block follows the attempt through three phases: preamble/start delimiter, frame data, and jam. It watches the collision input throughout. When a collision arrives it decides whether the data is cut off at once or whether the preamble finishes first. It then runs a jam of fixed length. After the jam it either schedules a retransmission after a truncated binary exponential backoff or closes the frame with a status report.

The backoff counts whole slot times. Its random draw comes from a free-running LFSR sampled when the jam ends. An optional mode holds the backoff count still while receive carrier is present. A second mode abandons the frame on its first collision instead of retrying. All outputs are registered, and every step is paced by a bit-time strobe.

Top module: `csma_retry_ctrl`

## Requirements
- R1: A collision seen while the preamble/start delimiter is going out does not shorten it. On the bit tick that completes `PRE_BITS` preamble bits, `txAbort` pulses and `jamActive` rises, both in the same cycle.
- R2: A collision during the data phase, with fewer than `SLOT_BITS` data bit ticks sent, pulses `txAbort` and raises `jamActive` in the next cycle.
- R3: `jamActive` stays high for exactly `JAM_BITS` bit ticks and falls in the cycle after the last of them.
- R4: After the nth collision of a frame, with n < `MAX_ATTEMPTS` and the jam finished, `retryReq` pulses once. Before it, exactly r·`SLOT_BITS` counted bit ticks must pass, where 0 ≤ r < 2^min(n,`BACKOFF_CAP`). The tick in the same cycle as `retryReq` is not counted. A new preamble phase then begins.
- R5: When `frameEnd` arrives during the data phase with no collision, `doneValid` pulses with no error flag set. `statOne` is set if exactly one retry was made, and `statMore` if two or more were made.
- R6: If the `MAX_ATTEMPTS`th attempt also collides, then after its jam `doneValid` pulses with only `statRetryErr` set. No `retryReq` follows.
- R7: With `retryDisable` high, the first collision ends the frame after its jam. `doneValid` pulses with only `statRetryErr` set.
- R8: A data-phase collision after `SLOT_BITS` or more data bit ticks is late. It aborts and jams like R2. After the jam, `doneValid` pulses with `statLateCol` set and no retry. `statOne`/`statMore` report the retries made before it.
- R9: With `modBackoff` high, a bit tick that arrives while `crsIn` is high is not counted by the backoff.
- R10: After reset, all outputs are low and the block is idle.
- R11: `frameReq` is ignored while a frame is in progress, and `colIn` is ignored during jam and backoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One bit time has elapsed on the medium |
| frameReq | input | 1 | Start a new frame (taken only when idle) |
| frameEnd | input | 1 | Serialiser sent the last frame bit |
| colIn | input | 1 | Collision detected |
| crsIn | input | 1 | Receive carrier sensed |
| retryDisable | input | 1 | Abandon the frame on its first collision |
| modBackoff | input | 1 | Pause backoff counting while carrier is present |
| txAbort | output | 1 | Pulse: stop sending frame data |
| jamActive | output | 1 | Jam pattern is being sent |
| retryReq | output | 1 | Pulse: restart the frame from preamble |
| doneValid | output | 1 | Pulse: frame finished, flags valid |
| statOne | output | 1 | Exactly one retry was made |
| statMore | output | 1 | Two or more retries were made |
| statRetryErr | output | 1 | Retry limit reached or retries disabled |
| statLateCol | output | 1 | Frame ended on a late collision |

## Verification
The bench builds the block with `PRE_BITS`=4, `SLOT_BITS`=16, `JAM_BITS`=4, `BACKOFF_CAP`=4 and `MAX_ATTEMPTS`=16. With these short phases, a frame that collides on all sixteen attempts finishes in a few thousand cycles. The truncation of the backoff window also shows up from the fifth retry on. The late-collision edge is probed on both sides of sixteen data bits. The bit strobe runs both continuously and with gaps, and carrier toggles so that the paused backoff count differs from the raw tick count.

// File: rtl/csma_retry_pkg.sv
package csma_retry_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_DATA,
    PH_JAM,
    PH_BACKOFF
  } txPhase_e;

  // strobes from the control FSM to the counters
  typedef struct packed {
    logic clrBit;
    logic cntEn;
    logic cntBackoff;
    logic clrCol;
    logic incCol;
    logic loadBackoff;
    logic decSlot;
  } dpCtl_s;

endpackage

// File: rtl/csma_retry_dp.sv
module csma_retry_dp
  import csma_retry_pkg::*;
#(
  parameter int PRE_BITS     = 64,
  parameter int SLOT_BITS    = 512,
  parameter int JAM_BITS     = 32,
  parameter int MAX_ATTEMPTS = 16,
  parameter int BACKOFF_CAP  = 10,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bitTick,
  input  logic   crsIn,
  input  logic   modBackoff,
  input  dpCtl_s ctl,
  output logic   preDone,
  output logic   jamDone,
  output logic   slotTick,
  output logic   slotZero,
  output logic   isLate,
  output logic [$clog2(MAX_ATTEMPTS+1)-1:0] colCnt
);

  localparam int MAX_AB = (SLOT_BITS > PRE_BITS) ? SLOT_BITS : PRE_BITS;
  localparam int MAXB   = (MAX_AB > JAM_BITS) ? MAX_AB : JAM_BITS;
  localparam int BIT_W  = $clog2(MAXB + 1);
  localparam int COL_W  = $clog2(MAX_ATTEMPTS + 1);
  localparam int LFSR_W = 16;

  logic [BIT_W-1:0]       bitCnt;
  logic [BACKOFF_CAP-1:0] slotLeft;
  logic [BACKOFF_CAP-1:0] boMask;
  logic [LFSR_W-1:0]      lfsr;
  logic                   eligible;
  int                     kSel;

  // a tick counts unless the backoff is paused by carrier
  assign eligible = bitTick && ctl.cntEn && !(ctl.cntBackoff && modBackoff && crsIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (ctl.clrBit) begin
      bitCnt <= '0;
    end else if (eligible && (bitCnt != BIT_W'(MAXB))) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign preDone  = bitTick && (bitCnt == BIT_W'(PRE_BITS - 1));
  assign jamDone  = bitTick && (bitCnt == BIT_W'(JAM_BITS - 1));
  assign slotTick = eligible && (bitCnt == BIT_W'(SLOT_BITS - 1));
  assign isLate   = (bitCnt >= BIT_W'(SLOT_BITS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt <= '0;
    end else if (ctl.clrCol) begin
      colCnt <= '0;
    end else if (ctl.incCol && (colCnt != COL_W'(MAX_ATTEMPTS))) begin
      colCnt <= colCnt + 1'b1;
    end
  end

  // free-running maximal-length LFSR, x^16+x^14+x^13+x^11+1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= LFSR_SEED;
    end else begin
      lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  end

  // window exponent k = min(n, cap)
  always_comb begin
    kSel   = (colCnt > COL_W'(BACKOFF_CAP)) ? BACKOFF_CAP : int'(colCnt);
    boMask = BACKOFF_CAP'((1 << kSel) - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotLeft <= '0;
    end else if (ctl.loadBackoff) begin
      slotLeft <= lfsr[BACKOFF_CAP-1:0] & boMask;
    end else if (ctl.decSlot && (slotLeft != '0)) begin
      slotLeft <= slotLeft - 1'b1;
    end
  end

  assign slotZero = (slotLeft == '0);

  // R4: a freshly drawn backoff never exceeds the window of this retry
  a_r4_slot_bound: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.loadBackoff) |-> (slotLeft <= $past(boMask)));

  // R9: paused ticks leave the slot position untouched
  a_r9_pause_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.cntBackoff && modBackoff && crsIn && !ctl.clrBit) |=> $stable(bitCnt));

  // R6: collision count never passes the attempt limit
  a_r6_col_limit: assert property (@(posedge clk) disable iff (!rstN)
    colCnt <= COL_W'(MAX_ATTEMPTS));

endmodule

// File: rtl/csma_retry_fsm.sv
module csma_retry_fsm
  import csma_retry_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   frameReq,
  input  logic   frameEnd,
  input  logic   colIn,
  input  logic   retryDisable,
  input  logic   preDone,
  input  logic   jamDone,
  input  logic   slotTick,
  input  logic   slotZero,
  input  logic   isLate,
  input  logic [$clog2(MAX_ATTEMPTS+1)-1:0] colCnt,
  output dpCtl_s ctl,
  output logic   txAbort,
  output logic   jamActive,
  output logic   retryReq,
  output logic   doneValid,
  output logic   statOne,
  output logic   statMore,
  output logic   statRetryErr,
  output logic   statLateCol
);

  localparam int COL_W = $clog2(MAX_ATTEMPTS + 1);

  txPhase_e phase, phaseN;
  logic colPend, colPendN;
  logic lateHit, lateHitN;
  logic abortN, jamN, retryN, doneN, oneN, moreN, errN, lateN;

  always_comb begin
    ctl      = '0;
    phaseN   = phase;
    colPendN = colPend;
    lateHitN = lateHit;
    abortN   = 1'b0;
    jamN     = jamActive;
    retryN   = 1'b0;
    doneN    = 1'b0;
    oneN     = 1'b0;
    moreN    = 1'b0;
    errN     = 1'b0;
    lateN    = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (frameReq) begin
          ctl.clrBit = 1'b1;
          ctl.clrCol = 1'b1;
          colPendN   = 1'b0;
          phaseN     = PH_PRE;
        end
      end
      PH_PRE: begin
        ctl.cntEn = 1'b1;
        if (colIn) colPendN = 1'b1;
        if (preDone) begin
          ctl.clrBit = 1'b1;
          if (colPend || colIn) begin
            ctl.incCol = 1'b1;
            abortN     = 1'b1;
            jamN       = 1'b1;
            lateHitN   = 1'b0;
            phaseN     = PH_JAM;
          end else begin
            phaseN = PH_DATA;
          end
        end
      end
      PH_DATA: begin
        ctl.cntEn = 1'b1;
        if (colIn) begin
          ctl.clrBit = 1'b1;
          ctl.incCol = 1'b1;
          abortN     = 1'b1;
          jamN       = 1'b1;
          lateHitN   = isLate;
          phaseN     = PH_JAM;
        end else if (frameEnd) begin
          doneN  = 1'b1;
          oneN   = (colCnt == COL_W'(1));
          moreN  = (colCnt >= COL_W'(2));
          phaseN = PH_IDLE;
        end
      end
      PH_JAM: begin
        ctl.cntEn = 1'b1;
        if (jamDone) begin
          ctl.clrBit = 1'b1;
          jamN       = 1'b0;
          if (lateHit) begin
            doneN  = 1'b1;
            lateN  = 1'b1;
            oneN   = (colCnt == COL_W'(2));
            moreN  = (colCnt >= COL_W'(3));
            phaseN = PH_IDLE;
          end else if (retryDisable || (colCnt == COL_W'(MAX_ATTEMPTS))) begin
            doneN  = 1'b1;
            errN   = 1'b1;
            phaseN = PH_IDLE;
          end else begin
            ctl.loadBackoff = 1'b1;
            phaseN          = PH_BACKOFF;
          end
        end
      end
      PH_BACKOFF: begin
        ctl.cntEn      = 1'b1;
        ctl.cntBackoff = 1'b1;
        if (slotZero) begin
          ctl.clrBit = 1'b1;
          retryN     = 1'b1;
          colPendN   = 1'b0;
          phaseN     = PH_PRE;
        end else if (slotTick) begin
          ctl.clrBit  = 1'b1;
          ctl.decSlot = 1'b1;
        end
      end
      default: phaseN = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase        <= PH_IDLE;
      colPend      <= 1'b0;
      lateHit      <= 1'b0;
      txAbort      <= 1'b0;
      jamActive    <= 1'b0;
      retryReq     <= 1'b0;
      doneValid    <= 1'b0;
      statOne      <= 1'b0;
      statMore     <= 1'b0;
      statRetryErr <= 1'b0;
      statLateCol  <= 1'b0;
    end else begin
      phase        <= phaseN;
      colPend      <= colPendN;
      lateHit      <= lateHitN;
      txAbort      <= abortN;
      jamActive    <= jamN;
      retryReq     <= retryN;
      doneValid    <= doneN;
      statOne      <= oneN;
      statMore     <= moreN;
      statRetryErr <= errN;
      statLateCol  <= lateN;
    end
  end

  // R10: at most one event pulse per cycle
  a_r10_pulse_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txAbort, retryReq, doneValid}));

  // R3: the jam is always opened by an abort
  a_r3_jam_after_abort: assert property (@(posedge clk) disable iff (!rstN)
    $rose(jamActive) |-> txAbort);

  // R5: single and multiple retry flags exclude each other
  a_r5_flags_excl: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !(statOne && statMore));

  // R7: a retry error reports nothing else
  a_r7_err_alone: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && statRetryErr) |-> (!statOne && !statMore && !statLateCol));

  // R8: a late-collision report always follows a jam
  a_r8_late_after_jam: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && statLateCol) |-> $past(jamActive));

  // R4: a retry is never requested while jamming
  a_r4_retry_not_jam: assert property (@(posedge clk) disable iff (!rstN)
    retryReq |-> !jamActive);

endmodule

// File: rtl/csma_retry_ctrl.sv
module csma_retry_ctrl
  import csma_retry_pkg::*;
#(
  parameter int PRE_BITS     = 64,
  parameter int SLOT_BITS    = 512,
  parameter int JAM_BITS     = 32,
  parameter int MAX_ATTEMPTS = 16,
  parameter int BACKOFF_CAP  = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitTick,
  input  logic frameReq,
  input  logic frameEnd,
  input  logic colIn,
  input  logic crsIn,
  input  logic retryDisable,
  input  logic modBackoff,
  output logic txAbort,
  output logic jamActive,
  output logic retryReq,
  output logic doneValid,
  output logic statOne,
  output logic statMore,
  output logic statRetryErr,
  output logic statLateCol
);

  localparam int COL_W = $clog2(MAX_ATTEMPTS + 1);

  dpCtl_s           ctl;
  logic             preDone, jamDone, slotTick, slotZero, isLate;
  logic [COL_W-1:0] colCnt;

  csma_retry_dp #(
    .PRE_BITS    (PRE_BITS),
    .SLOT_BITS   (SLOT_BITS),
    .JAM_BITS    (JAM_BITS),
    .MAX_ATTEMPTS(MAX_ATTEMPTS),
    .BACKOFF_CAP (BACKOFF_CAP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .crsIn     (crsIn),
    .modBackoff(modBackoff),
    .ctl       (ctl),
    .preDone   (preDone),
    .jamDone   (jamDone),
    .slotTick  (slotTick),
    .slotZero  (slotZero),
    .isLate    (isLate),
    .colCnt    (colCnt)
  );

  csma_retry_fsm #(
    .MAX_ATTEMPTS(MAX_ATTEMPTS)
  ) u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .frameReq    (frameReq),
    .frameEnd    (frameEnd),
    .colIn       (colIn),
    .retryDisable(retryDisable),
    .preDone     (preDone),
    .jamDone     (jamDone),
    .slotTick    (slotTick),
    .slotZero    (slotZero),
    .isLate      (isLate),
    .colCnt      (colCnt),
    .ctl         (ctl),
    .txAbort     (txAbort),
    .jamActive   (jamActive),
    .retryReq    (retryReq),
    .doneValid   (doneValid),
    .statOne     (statOne),
    .statMore    (statMore),
    .statRetryErr(statRetryErr),
    .statLateCol (statLateCol)
  );

endmodule

// File: tb/csma_retry_ctrl_bench.sv
module csma_retry_ctrl_bench;

  localparam int PRE  = 4;
  localparam int SLOT = 16;
  localparam int JAM  = 4;
  localparam int MAXA = 16;
  localparam int CAP  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0, frameReq = 1'b0, frameEnd = 1'b0, colIn = 1'b0;
  logic crsIn = 1'b0, retryDisable = 1'b0, modBackoff = 1'b0;
  logic txAbort, jamActive, retryReq, doneValid;
  logic statOne, statMore, statRetryErr, statLateCol;

  always #10 clk = ~clk;

  csma_retry_ctrl #(
    .PRE_BITS(PRE), .SLOT_BITS(SLOT), .JAM_BITS(JAM),
    .MAX_ATTEMPTS(MAXA), .BACKOFF_CAP(CAP)
  ) u_csma_retry_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .frameReq(frameReq),
    .frameEnd(frameEnd), .colIn(colIn), .crsIn(crsIn),
    .retryDisable(retryDisable), .modBackoff(modBackoff),
    .txAbort(txAbort), .jamActive(jamActive), .retryReq(retryReq),
    .doneValid(doneValid), .statOne(statOne), .statMore(statMore),
    .statRetryErr(statRetryErr), .statLateCol(statLateCol)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // inputs as seen at each rising edge
  logic cRst = 1'b0, cTick = 1'b0, cReq = 1'b0, cEnd = 1'b0, cCol = 1'b0;
  logic cCrs = 1'b0, cRd = 1'b0, cMb = 1'b0;
  always @(posedge clk) begin
    cRst <= rstN; cTick <= bitTick; cReq <= frameReq; cEnd <= frameEnd;
    cCol <= colIn; cCrs <= crsIn; cRd <= retryDisable; cMb <= modBackoff;
  end

  // behavioural reference: 0 idle, 1 preamble, 2 data, 3 jam, 4 backoff
  int mState = 0, mBits = 0, mCols = 0, mElig = 0, mDoneCnt = 0;
  bit mPend = 0, mLate = 0, expJam = 0;
  bit lastOne, lastMore, lastErr, lastLate;

  always @(negedge clk) begin
    bit eAbort, eRetry, eDone, eOne, eMore, eErr, eLt;
    string abTag;
    eAbort = 0; eRetry = 0; eDone = 0; eOne = 0; eMore = 0; eErr = 0; eLt = 0;
    abTag = "R2";
    if (!cRst) begin
      mState = 0; mBits = 0; mCols = 0; expJam = 0; mPend = 0; mLate = 0;
    end else begin
      case (mState)
        0: if (cReq) begin mState = 1; mBits = 0; mCols = 0; mPend = 0; end
        1: begin
          if (cCol) mPend = 1;
          if (cTick) begin
            mBits++;
            if (mBits == PRE) begin
              mBits = 0;
              if (mPend) begin
                mState = 3; eAbort = 1; expJam = 1; mCols++; mLate = 0; abTag = "R1";
              end else mState = 2;
            end
          end
        end
        2: begin
          if (cCol) begin
            mLate = (mBits >= SLOT); mState = 3; eAbort = 1; expJam = 1;
            mCols++; mBits = 0; abTag = mLate ? "R8" : "R2";
          end else if (cEnd) begin
            eDone = 1; eOne = (mCols == 1); eMore = (mCols >= 2); mState = 0;
          end else if (cTick) mBits++;
        end
        3: if (cTick) begin
          mBits++;
          if (mBits == JAM) begin
            mBits = 0; expJam = 0;
            if (mLate) begin
              eDone = 1; eLt = 1; eOne = (mCols == 2); eMore = (mCols >= 3); mState = 0;
            end else if (cRd || mCols == MAXA) begin
              eDone = 1; eErr = 1; mState = 0;
            end else begin
              mState = 4; mElig = 0;
            end
          end
        end
        default: begin
          if (retryReq) begin
            int k;
            k = (mCols > CAP) ? CAP : mCols;
            eRetry = 1;
            chk((mElig % SLOT == 0) && (mElig / SLOT < (1 << k)),
                cMb ? "R9 paused backoff length" : "R4 backoff length", mElig, (mElig / SLOT) * SLOT);
            mState = 1; mBits = 0; mPend = 0;
          end else if (cTick && !(cMb && cCrs)) mElig++;
        end
      endcase
      if (eDone) mDoneCnt++;
    end
    chk(txAbort == eAbort, {abTag, " txAbort"}, txAbort, eAbort);
    chk(jamActive == expJam, "R3 jamActive", jamActive, expJam);
    chk(retryReq == eRetry, "R4 retryReq", retryReq, eRetry);
    chk(doneValid == eDone, "R5 doneValid", doneValid, eDone);
    if (eDone) begin
      chk({statOne, statMore, statRetryErr, statLateCol} == {eOne, eMore, eErr, eLt},
          eLt ? "R8 flags" : (eErr ? "R6 flags" : "R5 flags"),
          {statOne, statMore, statRetryErr, statLateCol}, {eOne, eMore, eErr, eLt});
      lastOne = statOne; lastMore = statMore; lastErr = statRetryErr; lastLate = statLateCol;
    end
  end

  // stimulus configuration
  bit goReq = 0, noiseOn = 0;
  int colWhere = 0, colBit = 0, numCols = 0, frameLen = 20, tickMode = 0, crsMode = 0;
  int cyc = 0;

  initial forever begin
    bit c;
    @(negedge clk);
    #2;
    cyc++;
    if (goReq && mState != 0) goReq = 0;
    c = ((mState == 1 && colWhere == 1) || (mState == 2 && colWhere == 2))
        && mCols < numCols && mBits == colBit;
    colIn    = c || (noiseOn && (mState == 3 || mState == 4) && (cyc % 3 == 0));
    frameEnd = (mState == 2) && mBits >= frameLen && !c;
    frameReq = goReq || (noiseOn && mState != 0 && (cyc % 2 == 0));
    bitTick  = (tickMode == 0) ? 1'b1 : (cyc % 3 != 0);
    crsIn    = (crsMode == 0) ? 1'b0 : ((cyc / 5) % 2 == 1);
  end

  task automatic runFrame(input int where, input int cbit, input int ncol, input int len,
                          input bit rd, input bit mb, input int tm, input int cm, input bit nz,
                          input bit xOne, input bit xMore, input bit xErr, input bit xLate,
                          input string tag);
    int startCnt;
    colWhere = where; colBit = cbit; numCols = ncol; frameLen = len;
    retryDisable = rd; modBackoff = mb; tickMode = tm; crsMode = cm; noiseOn = nz;
    startCnt = mDoneCnt;
    goReq = 1;
    while (mDoneCnt == startCnt) @(negedge clk);
    #1;
    chk({lastOne, lastMore, lastErr, lastLate} == {xOne, xMore, xErr, xLate}, tag,
        {lastOne, lastMore, lastErr, lastLate}, {xOne, xMore, xErr, xLate});
    noiseOn = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({txAbort, jamActive, retryReq, doneValid, statOne, statMore, statRetryErr, statLateCol} == 8'h00,
        "R10 reset outputs", {txAbort, jamActive, retryReq, doneValid}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    runFrame(0, 0, 0, 20, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 clean frame");
    runFrame(1, 1, 1, 20, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R1 preamble collision then one retry");
    runFrame(1, 0, 2, 20, 0, 0, 1, 0, 0, 0, 1, 0, 0, "R1 two preamble collisions gapped ticks");
    runFrame(2, 5, 3, 24, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R2 data collisions more retries");
    runFrame(2, 15, 1, 30, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R2 collision one tick before slot edge");
    runFrame(2, 16, 1, 30, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8 collision at slot edge is late");
    runFrame(2, 20, 1, 30, 0, 0, 1, 0, 0, 0, 0, 0, 1, "R8 late collision gapped ticks");
    runFrame(2, 3, 1, 20, 1, 0, 0, 0, 0, 0, 0, 1, 0, "R7 retry disabled first collision");
    runFrame(2, 4, MAXA, 20, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R6 all attempts collide");
    runFrame(2, 4, 6, 20, 0, 1, 0, 1, 0, 0, 1, 0, 0, "R9 backoff paused by carrier");
    runFrame(2, 4, 6, 20, 0, 0, 1, 1, 0, 0, 1, 0, 0, "R4 carrier ignored without pause mode");
    runFrame(2, 6, 3, 20, 0, 1, 1, 1, 1, 0, 1, 0, 0, "R11 requests and collisions ignored when busy");
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

endmodule